// File: doc/BRIEF.md
# RC Pulse-Frame Channel Decoder

This block turns a demodulated carrier-present signal from a radio-control receiver into servo and switch outputs. Each frame begins with a short carrier dropout. Each further dropout ends one slot and starts the next. The block counts the dropouts with a small saturating counter. The first two slots drive two proportional servo outputs. Any fixed-width pulses that follow advance the counter but drive no servo.

When the carrier stays present longer than a programmable sync time, the frame has ended. A read strobe then copies the two low counter bits into held switch outputs. A clear strobe follows at once and returns the counter to zero for the next frame. All timing is counted in clock cycles. Only carrier dropouts (falling edges) are used, so a fixed delay in the detector upstream does not change any measured width.

Top module: `rc_frame_decoder`

## Requirements
- R1: `carrier_in` is 1 when the carrier is present. Each 1-to-0 transition advances the slot counter by one, after a two-flop input synchroniser.
- R2: `servo_ch1` is high exactly while the counter holds 1. Its width equals the first dropout length plus the first channel interval.
- R3: `servo_ch2` is high exactly while the counter holds 2. Its width equals the second dropout length plus the second channel interval.
- R4: Counter values other than 1 and 2 produce no servo output. The two servo outputs are never high together.
- R5: The sync timer is cleared while the carrier is absent. A carrier-present stretch shorter than SYNC_CYC cycles produces no read strobe.
- R6: A carrier-present stretch of SYNC_CYC cycles starts `read_strobe`, which stays high for READ_CYC cycles.
- R7: `clear_strobe` goes high in the cycle after `read_strobe` ends and stays high for CLR_CYC cycles. It returns the counter to 0, and both servo outputs are low while it is high.
- R8: During the read strobe, `dig_ch_a` takes counter bit 0 and `dig_ch_b` takes counter bit 1. Both hold their value until the next read strobe.
- R9: The counter stops at 7 instead of wrapping when more dropouts arrive than it can count.
- R10: While `rst` is high, the counter, timers, strobes and switch outputs all return to 0 on the next clock edge.
- R11: One unbroken carrier-present stretch gives at most one read/clear sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| carrier_in | input | 1 | Demodulated carrier present (1) or absent (0), asynchronous |
| servo_ch1 | output | 1 | Proportional channel 1 pulse |
| servo_ch2 | output | 1 | Proportional channel 2 pulse |
| dig_ch_a | output | 1 | Held switch channel A (counter bit 0) |
| dig_ch_b | output | 1 | Held switch channel B (counter bit 1) |
| read_strobe | output | 1 | High while the switch bits are being captured |
| clear_strobe | output | 1 | High while the counter is being cleared |

## Verification
The in-RTL properties check the following on every cycle:
- single-cycle edge pulses;
- the counter stepping by one and then saturating;
- the clear strobe following the read strobe directly, with the two never overlapping;
- both servos being low during the clear;
- the switch outputs holding between reads;
- the reset values.

Other behaviour only whole frames can show, so the bench scenarios cover it:
- servo pulse widths measured against the dropout and interval lengths;
- the switch values for zero to six trailing pulses, including saturation;
- the absence of a read strobe on long but sub-threshold intervals;
- exactly one read per sync stretch.

// File: rtl/rcfd_pkg.sv
package rcfd_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_READ  = 2'd1,
      SEQ_CLEAR = 2'd2
   } seq_state_t;

   function automatic int unsigned bits_for(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/rcfd_in_sync.sv
module rcfd_in_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic level_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   initial assert (STAGES >= 2) else $error("rcfd_in_sync: STAGES must be at least 2");

   generate
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk) begin
            if (rst) chain_q <= '1;
            else     chain_q <= {chain_q[0], din};
         end
      end else begin : g_many
         always_ff @(posedge clk) begin
            if (rst) chain_q <= '1;
            else     chain_q <= {chain_q[STAGES-2:0], din};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b1;
      else     prev_q <= chain_q[STAGES-1];
   end

   assign level_o = chain_q[STAGES-1];
   assign fall_o  = prev_q & ~chain_q[STAGES-1];

   p_fall_single_r1: assert property (@(posedge clk) disable iff (rst)
      fall_o |=> !fall_o);

endmodule

// File: rtl/rcfd_slot_ctr.sv
module rcfd_slot_ctr #(
   parameter int unsigned CNT_W    = 3,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clear_i,
   input  logic             step_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] TOP = '1;

   logic [CNT_W-1:0] nxt;

   initial assert (CNT_W >= 2) else $error("rcfd_slot_ctr: CNT_W must be at least 2");

   generate
      if (SATURATE) begin : g_sat
         assign nxt = (cnt_o == TOP) ? cnt_o : cnt_o + 1'b1;
      end else begin : g_wrap
         assign nxt = cnt_o + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || clear_i) cnt_o <= '0;
      else if (step_i)    cnt_o <= nxt;
   end

   p_step_r1: assert property (@(posedge clk) disable iff (rst)
      (step_i && !clear_i && cnt_o != TOP) |=> (cnt_o == $past(cnt_o) + 1'b1));

   p_clear_r7: assert property (@(posedge clk) disable iff (rst)
      clear_i |=> (cnt_o == '0));

   if (SATURATE) begin : g_sat_chk
      p_saturate_r9: assert property (@(posedge clk) disable iff (rst)
         (cnt_o == TOP && !clear_i) |=> (cnt_o == TOP));
   end

endmodule

// File: rtl/rcfd_frame_seq.sv
module rcfd_frame_seq
   import rcfd_pkg::*;
#(
   parameter int unsigned SYNC_CYC = 175000,
   parameter int unsigned READ_CYC = 500,
   parameter int unsigned CLR_CYC  = 500
) (
   input  logic clk,
   input  logic rst,
   input  logic present_i,
   output logic read_o,
   output logic clear_o
);
   localparam int unsigned TMR_W  = bits_for(SYNC_CYC + 1);
   localparam int unsigned PH_MAX = (READ_CYC > CLR_CYC) ? READ_CYC : CLR_CYC;
   localparam int unsigned PH_W   = bits_for(PH_MAX);
   localparam logic [TMR_W-1:0] TMR_FULL = TMR_W'(SYNC_CYC);
   localparam logic [TMR_W-1:0] TMR_HIT  = TMR_W'(SYNC_CYC - 1);
   localparam logic [PH_W-1:0]  RD_LAST  = PH_W'(READ_CYC - 1);
   localparam logic [PH_W-1:0]  CL_LAST  = PH_W'(CLR_CYC - 1);

   initial assert (SYNC_CYC >= 2) else $error("rcfd_frame_seq: SYNC_CYC too small");
   initial assert (READ_CYC >= 1 && CLR_CYC >= 1) else $error("rcfd_frame_seq: strobe length zero");

   logic [TMR_W-1:0] tmr_q;
   logic [PH_W-1:0]  ph_q;
   seq_state_t       st_q;
   logic             hit;

   always_ff @(posedge clk) begin
      if (rst || !present_i)    tmr_q <= '0;
      else if (tmr_q != TMR_FULL) tmr_q <= tmr_q + 1'b1;
   end

   assign hit = present_i && (tmr_q == TMR_HIT);

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q <= SEQ_IDLE;
         ph_q <= '0;
      end else begin
         unique case (st_q)
            SEQ_IDLE: begin
               ph_q <= '0;
               if (hit) st_q <= SEQ_READ;
            end
            SEQ_READ: begin
               if (ph_q == RD_LAST) begin
                  st_q <= SEQ_CLEAR;
                  ph_q <= '0;
               end else ph_q <= ph_q + 1'b1;
            end
            SEQ_CLEAR: begin
               if (ph_q == CL_LAST) begin
                  st_q <= SEQ_IDLE;
                  ph_q <= '0;
               end else ph_q <= ph_q + 1'b1;
            end
            default: st_q <= SEQ_IDLE;
         endcase
      end
   end

   assign read_o  = (st_q == SEQ_READ);
   assign clear_o = (st_q == SEQ_CLEAR);

   p_read_needs_carrier_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(read_o) |-> $past(present_i));

   p_clear_follows_read_r7: assert property (@(posedge clk) disable iff (rst)
      $fell(read_o) |-> clear_o);

   p_strobes_apart_r7: assert property (@(posedge clk) disable iff (rst)
      !(read_o && clear_o));

endmodule

// File: rtl/rc_frame_decoder.sv
module rc_frame_decoder #(
   parameter int unsigned CNT_W       = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned SYNC_CYC    = 175000,
   parameter int unsigned READ_CYC    = 500,
   parameter int unsigned CLR_CYC     = 500,
   parameter int unsigned SLOT_CH1    = 1,
   parameter int unsigned SLOT_CH2    = 2,
   parameter bit          SATURATE    = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic carrier_in,
   output logic servo_ch1,
   output logic servo_ch2,
   output logic dig_ch_a,
   output logic dig_ch_b,
   output logic read_strobe,
   output logic clear_strobe
);
   localparam logic [CNT_W-1:0] SLOT1 = CNT_W'(SLOT_CH1);
   localparam logic [CNT_W-1:0] SLOT2 = CNT_W'(SLOT_CH2);

   initial assert (SLOT_CH1 != SLOT_CH2) else $error("rc_frame_decoder: slots must differ");
   initial assert (SLOT_CH1 < (1 << CNT_W) && SLOT_CH2 < (1 << CNT_W))
      else $error("rc_frame_decoder: slot out of counter range");
   initial assert (SLOT_CH1 != 0 && SLOT_CH2 != 0) else $error("rc_frame_decoder: slot 0 is the idle slot");

   logic             present;
   logic             fall;
   logic [CNT_W-1:0] cnt;
   logic             rd, clr;

   rcfd_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .din(carrier_in), .level_o(present), .fall_o(fall));

   rcfd_slot_ctr #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_ctr (
      .clk(clk), .rst(rst), .clear_i(clr), .step_i(fall), .cnt_o(cnt));

   rcfd_frame_seq #(.SYNC_CYC(SYNC_CYC), .READ_CYC(READ_CYC), .CLR_CYC(CLR_CYC)) u_seq (
      .clk(clk), .rst(rst), .present_i(present), .read_o(rd), .clear_o(clr));

   always_ff @(posedge clk) begin
      if (rst) begin
         dig_ch_a <= 1'b0;
         dig_ch_b <= 1'b0;
      end else if (rd) begin
         dig_ch_a <= cnt[0];
         dig_ch_b <= cnt[1];
      end
   end

   assign servo_ch1    = (cnt == SLOT1) && !clr;
   assign servo_ch2    = (cnt == SLOT2) && !clr;
   assign read_strobe  = rd;
   assign clear_strobe = clr;

   p_servo_excl_r4: assert property (@(posedge clk) disable iff (rst)
      !(servo_ch1 && servo_ch2));

   p_servo_low_clear_r7: assert property (@(posedge clk) disable iff (rst)
      clear_strobe |-> (!servo_ch1 && !servo_ch2));

   p_dig_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !read_strobe |=> ($stable(dig_ch_a) && $stable(dig_ch_b)));

   p_rst_clear_r10: assert property (@(posedge clk)
      rst |=> (!dig_ch_a && !dig_ch_b && !read_strobe && !clear_strobe));

endmodule

// File: tb/rc_frame_decoder_tb_top.sv
`timescale 1ns/1ps
module rc_frame_decoder_tb_top;
   localparam int SYNC_CYC = 200;
   localparam int READ_CYC = 5;
   localparam int CLR_CYC  = 5;
   localparam int TM       = 20;
   localparam int DGAP     = 30;
   localparam int SGAP     = 600;

   // columns: ch1 interval, ch2 interval, trailing pulses, expected A, expected B
   localparam int VEC [0:5][0:4] = '{
      '{40, 90, 1, 1, 1},
      '{100, 40, 2, 0, 0},
      '{60, 60, 3, 1, 0},
      '{25, 120, 4, 0, 1},
      '{80, 30, 0, 0, 1},
      '{50, 50, 6, 1, 1}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic carrier_in = 1'b1;
   logic servo_ch1, servo_ch2, dig_ch_a, dig_ch_b, read_strobe, clear_strobe;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   int w1 = 0, w2 = 0, rd_cyc = 0, rd_rise = 0, cl_cyc = 0, order_bad = 0;
   logic rd_prev = 1'b0;

   always #10 clk = ~clk;

   rc_frame_decoder #(.SYNC_CYC(SYNC_CYC), .READ_CYC(READ_CYC), .CLR_CYC(CLR_CYC)) dut_i (
      .clk(clk), .rst(rst), .carrier_in(carrier_in),
      .servo_ch1(servo_ch1), .servo_ch2(servo_ch2),
      .dig_ch_a(dig_ch_a), .dig_ch_b(dig_ch_b),
      .read_strobe(read_strobe), .clear_strobe(clear_strobe));

   always @(negedge clk) begin
      if (servo_ch1) w1++;
      if (servo_ch2) w2++;
      if (read_strobe) rd_cyc++;
      if (clear_strobe) cl_cyc++;
      if (read_strobe && !rd_prev) rd_rise++;
      if (rd_prev && !read_strobe && !clear_strobe) order_bad++;
      rd_prev = read_strobe;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic hold(input logic v, input int n);
      carrier_in = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic frame(input int c1, input int c2, input int nd);
      hold(1'b0, TM); hold(1'b1, c1);
      hold(1'b0, TM); hold(1'b1, c2);
      for (int i = 0; i < nd; i++) begin
         hold(1'b0, TM); hold(1'b1, DGAP);
      end
      hold(1'b1, SGAP);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int a1, a2, ar, arc, acl, ob;
      repeat (5) @(negedge clk);
      // R10: outputs while in reset
      check(!servo_ch1 && !servo_ch2 && !dig_ch_a && !dig_ch_b && !read_strobe && !clear_strobe,
            "R10 reset state", {servo_ch1, servo_ch2, dig_ch_a, dig_ch_b, read_strobe, clear_strobe}, 0);
      rst = 1'b0;
      repeat (300) @(negedge clk);

      for (int v = 0; v < 6; v++) begin
         a1 = w1; a2 = w2; ar = rd_rise; arc = rd_cyc; acl = cl_cyc; ob = order_bad;
         frame(VEC[v][0], VEC[v][1], VEC[v][2]);
         check(w1 - a1 == TM + VEC[v][0], "R2 servo1 width", w1 - a1, TM + VEC[v][0]);
         if (VEC[v][2] > 0)
            check(w2 - a2 == TM + VEC[v][1], "R3 servo2 width", w2 - a2, TM + VEC[v][1]);
         check(dig_ch_a == VEC[v][3][0], "R8 R1 R9 channel A", dig_ch_a, VEC[v][3]);
         check(dig_ch_b == VEC[v][4][0], "R8 R1 R9 channel B", dig_ch_b, VEC[v][4]);
         check(rd_rise - ar == 1, "R11 one read per sync", rd_rise - ar, 1);
         check(rd_cyc - arc == READ_CYC, "R6 read length", rd_cyc - arc, READ_CYC);
         check(cl_cyc - acl == CLR_CYC, "R7 clear length", cl_cyc - acl, CLR_CYC);
         check(order_bad == ob, "R7 clear follows read", order_bad - ob, 0);
         check(!servo_ch1 && !servo_ch2, "R4 R7 servos idle after clear",
               {servo_ch1, servo_ch2}, 0);
      end

      // R5: intervals just under the sync time start no read
      ar = rd_rise; a1 = w1;
      hold(1'b0, TM); hold(1'b1, SYNC_CYC - 50);
      hold(1'b0, TM); hold(1'b1, SYNC_CYC - 10);
      check(rd_rise == ar, "R5 no read on long interval", rd_rise - ar, 0);
      check(dig_ch_a && dig_ch_b, "R8 hold mid-frame", {dig_ch_a, dig_ch_b}, 3);
      hold(1'b0, TM); hold(1'b1, DGAP); hold(1'b0, TM); hold(1'b1, SGAP);
      check(w1 - a1 == TM + SYNC_CYC - 50, "R2 servo1 long width", w1 - a1, TM + SYNC_CYC - 50);
      check(!dig_ch_a && !dig_ch_b, "R8 four slots give 00", {dig_ch_a, dig_ch_b}, 0);
      check(rd_rise - ar == 1, "R5 single read at sync", rd_rise - ar, 1);

      // R4: trailing slots drive no servo
      frame(40, 40, 1);
      a1 = w1; a2 = w2;
      hold(1'b0, TM); hold(1'b1, 40); hold(1'b0, TM); hold(1'b1, 40);
      hold(1'b0, TM);
      check(!servo_ch1 && !servo_ch2, "R4 slot 3 no servo", {servo_ch1, servo_ch2}, 0);
      hold(1'b1, 40); hold(1'b0, TM);
      check(!servo_ch1 && !servo_ch2, "R4 slot 4 no servo", {servo_ch1, servo_ch2}, 0);
      hold(1'b1, SGAP);

      // R10: reset after a latched 1
      frame(40, 40, 1);
      check(dig_ch_a && dig_ch_b, "R8 latched 11", {dig_ch_a, dig_ch_b}, 3);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check(!dig_ch_a && !dig_ch_b && !servo_ch1 && !servo_ch2, "R10 reset clears",
            {dig_ch_a, dig_ch_b, servo_ch1, servo_ch2}, 0);
      rst = 1'b0;
      repeat (20) @(negedge clk);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule